// File: doc/BRIEF.md
# 16-bit Prescaled Up/Down Timer with Interrupt Flags

This block is a general-purpose 16-bit timer that sits on a simple word-wide register bus (address, write data, write strobe, read strobe, read data). Software picks a count direction, a power-of-two clock divider and an optional single-run behaviour, then writes a start command. The counter advances once per divided tick. Counting down, it reloads from a programmable reload value each time it passes below zero, which gives a periodic event. Counting up, it wraps to zero after it reaches the reload value.

Each wrap raises a sticky event flag: bit 1 for a down-count underflow and bit 0 for an up-count overflow. The flags can be read directly. They are set through a separate set-alias address and cleared through a separate clear-alias address, so software needs no read-modify-write. The interrupt line is the OR of the flags masked by an enable register. The counter itself can be written at any time, which is how software preloads a delay before a start.

Top module: `tmr16_top`

## Requirements
- R1: After reset, control reads 0, reload reads 0xFFFF, counter reads 0, flags read 0, the interrupt line is low and the timer is stopped.
- R2: Byte address map: control 0x00 (divider code in bits 27:24, single-run enable in bit 4, direction in bits 1:0 where 1 means down and any other value means up), command 0x04, interrupt enable 0x0C, flags 0x10, flag-set alias 0x14, flag-clear alias 0x18, reload 0x1C, counter 0x24. Command, flag-set and flag-clear read as 0, and so does any unmapped address.
- R3: With divider code n, the counter steps once every 2^n clocks. The divider restarts on a start command, so the first step lands 2^n clocks after the start write.
- R4: Counting down, a tick at a nonzero count subtracts one. A tick at zero loads the reload value and sets flag bit 1.
- R5: Counting up, a tick below the reload value adds one. A tick at the reload value loads zero and sets flag bit 0.
- R6: With single-run enabled, the tick that wraps the counter also stops the timer, and the counter then holds.
- R7: Writing command bit 0 starts the timer and writing command bit 1 stops it. If both bits are written together the timer stops. A stopped counter holds its value.
- R8: A write to the counter address loads the written low 16 bits. A load takes precedence over a tick in the same cycle.
- R9: Writing 1s to the flag-set alias sets those flags, and writing 1s to the flag-clear alias clears them. The interrupt line is high exactly when flags AND enable is nonzero.
- R10: If a hardware wrap event or a flag-set write lands in the same cycle as a flag-clear write of the same bit, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one access per asserted cycle |
| bus_rd | input | 1 | Read strobe; read data is 0 when low |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level interrupt, flags masked by enable |

## Verification
On every cycle the assertions check the following: a down-count wrap reloads from the reload register, a single-run wrap halts the timer, a stop command overrides a start, a stopped and unloaded counter holds, the divider never emits back-to-back ticks at a nonzero code, and a hardware wrap event beats a simultaneous clear. The exact cycle of each step at a given divider code needs the bench's directed scenarios, which count clocks from the start write. So do the contents of the address map, the reset values and the masking of the interrupt line.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;

    localparam int BUS_AW = 8;
    localparam int BUS_DW = 32;
    localparam int FLAG_W = 2;

    localparam logic [BUS_AW-1:0] A_CTRL  = 8'h00;
    localparam logic [BUS_AW-1:0] A_CMD   = 8'h04;
    localparam logic [BUS_AW-1:0] A_IEN   = 8'h0C;
    localparam logic [BUS_AW-1:0] A_FLAGS = 8'h10;
    localparam logic [BUS_AW-1:0] A_FSET  = 8'h14;
    localparam logic [BUS_AW-1:0] A_FCLR  = 8'h18;
    localparam logic [BUS_AW-1:0] A_RELD  = 8'h1C;
    localparam logic [BUS_AW-1:0] A_COUNT = 8'h24;

    localparam int FLG_OVF = 0;
    localparam int FLG_UNF = 1;

    localparam int CMD_GO   = 0;
    localparam int CMD_HALT = 1;

    typedef struct packed {
        logic [3:0] div_code;
        logic       single;
        logic [1:0] dir;
    } ctrl_t;

    function automatic ctrl_t ctrl_from_word(input logic [BUS_DW-1:0] w);
        ctrl_t c;
        c.div_code = w[27:24];
        c.single   = w[4];
        c.dir      = w[1:0];
        return c;
    endfunction

    function automatic logic [BUS_DW-1:0] ctrl_to_word(input ctrl_t c);
        logic [BUS_DW-1:0] w;
        w        = '0;
        w[27:24] = c.div_code;
        w[4]     = c.single;
        w[1:0]   = c.dir;
        return w;
    endfunction

    function automatic logic is_down(input ctrl_t c);
        return c.dir == 2'd1;
    endfunction

endpackage

// File: rtl/tmr16_presc.sv
module tmr16_presc #(
    parameter int CODE_W = 4,
    localparam int DIV_W = (1 << CODE_W) - 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              restart,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = '0;
        for (int i = 0; i < DIV_W; i++) begin
            if (i < int'(code)) limit[i] = 1'b1;
        end
    end

    assign tick = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || !run || restart) div_q <= '0;
        else if (tick)              div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    // R3: after a tick the divider restarts, so a nonzero code cannot tick twice in a row
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> (!tick || limit == '0));

endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] reload,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             ovf_evt,
    output logic             unf_evt
);
    logic at_zero, at_top;

    assign at_zero = (count == '0);
    assign at_top  = (count == reload);
    assign unf_evt = tick && !load_en && down && at_zero;
    assign ovf_evt = tick && !load_en && !down && at_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load_en) begin
            count <= load_val;
        end else if (tick) begin
            if (down) count <= at_zero ? reload : count - 1'b1;
            else      count <= at_top ? '0 : count + 1'b1;
        end
    end

    // R4: a down-count underflow reloads from the reload register
    a_r4_unf_reload: assert property (@(posedge clk) disable iff (rst)
        unf_evt |=> count == $past(reload));

    // R5: an up-count overflow returns to zero
    a_r5_ovf_zero: assert property (@(posedge clk) disable iff (rst)
        ovf_evt |=> count == '0);

endmodule

// File: rtl/tmr16_regs.sv
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              ovf_evt,
    input  logic              unf_evt,
    output ctrl_t             ctrl,
    output logic [CNT_W-1:0]  reload,
    output logic              running,
    output logic              restart,
    output logic              load_en,
    output logic [CNT_W-1:0]  load_val,
    output logic              irq
);
    logic              wr_ctrl, wr_cmd, wr_ien, wr_fset, wr_fclr, wr_reld;
    logic              go, halt;
    logic [FLAG_W-1:0] ien, flags, set_m, clr_m, hw_m;
    logic              unused_wbits;

    assign wr_ctrl  = bus_wr && bus_addr == A_CTRL;
    assign wr_cmd   = bus_wr && bus_addr == A_CMD;
    assign wr_ien   = bus_wr && bus_addr == A_IEN;
    assign wr_fset  = bus_wr && bus_addr == A_FSET;
    assign wr_fclr  = bus_wr && bus_addr == A_FCLR;
    assign wr_reld  = bus_wr && bus_addr == A_RELD;
    assign load_en  = bus_wr && bus_addr == A_COUNT;
    assign load_val = bus_wdata[CNT_W-1:0];

    assign go      = wr_cmd && bus_wdata[CMD_GO];
    assign halt    = wr_cmd && bus_wdata[CMD_HALT];
    assign restart = go && !halt;

    assign set_m = wr_fset ? bus_wdata[FLAG_W-1:0] : '0;
    assign clr_m = wr_fclr ? bus_wdata[FLAG_W-1:0] : '0;
    always_comb begin
        hw_m          = '0;
        hw_m[FLG_OVF] = ovf_evt;
        hw_m[FLG_UNF] = unf_evt;
    end

    assign unused_wbits = ^bus_wdata[BUS_DW-1:CNT_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            reload  <= '1;
            ien     <= '0;
            flags   <= '0;
            running <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl   <= ctrl_from_word(bus_wdata);
            if (wr_reld) reload <= bus_wdata[CNT_W-1:0];
            if (wr_ien)  ien    <= bus_wdata[FLAG_W-1:0];
            flags <= (flags & ~clr_m) | set_m | hw_m;
            if (halt)                                    running <= 1'b0;
            else if (go)                                 running <= 1'b1;
            else if ((ovf_evt || unf_evt) && ctrl.single) running <= 1'b0;
        end
    end

    assign irq = |(flags & ien);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  bus_rdata = ctrl_to_word(ctrl);
                A_IEN:   bus_rdata[FLAG_W-1:0] = ien;
                A_FLAGS: bus_rdata[FLAG_W-1:0] = flags;
                A_RELD:  bus_rdata[CNT_W-1:0]  = reload;
                A_COUNT: bus_rdata[CNT_W-1:0]  = count;
                default: bus_rdata = '0;
            endcase
        end
    end

    // R7: a stop bit always leaves the timer stopped, even with start
    a_r7_stop_wins: assert property (@(posedge clk) disable iff (rst)
        halt |=> !running);

    // R6: a single-run wrap with no command write halts the timer
    a_r6_single_halt: assert property (@(posedge clk) disable iff (rst)
        ((ovf_evt || unf_evt) && ctrl.single && !wr_cmd) |=> !running);

    // R10: a hardware underflow survives a same-cycle clear
    a_r10_hw_beats_clear: assert property (@(posedge clk) disable iff (rst)
        unf_evt |=> flags[FLG_UNF]);

endmodule

// File: rtl/tmr16_top.sv
module tmr16_top
    import tmr16_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [BUS_DW-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl;
    logic [CNT_W-1:0] reload, count, load_val;
    logic             running, restart, load_en, tick, ovf_evt, unf_evt;

    tmr16_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .count(count), .ovf_evt(ovf_evt), .unf_evt(unf_evt),
        .ctrl(ctrl), .reload(reload), .running(running), .restart(restart),
        .load_en(load_en), .load_val(load_val), .irq(irq)
    );

    tmr16_presc #(.CODE_W(CODE_W)) u_presc (
        .clk(clk), .rst(rst), .run(running), .restart(restart),
        .code(ctrl.div_code[CODE_W-1:0]), .tick(tick)
    );

    tmr16_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst(rst), .tick(tick), .down(is_down(ctrl)),
        .reload(reload), .load_en(load_en), .load_val(load_val),
        .count(count), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
    );

    // R7: a stopped counter that is not being loaded keeps its value
    a_r7_hold_stopped: assert property (@(posedge clk) disable iff (rst)
        (!running && !load_en) |=> $stable(count));

    // R8: a counter write shows up in the counter on the next cycle
    a_r8_load: assert property (@(posedge clk) disable iff (rst)
        load_en |=> count == $past(load_val));

endmodule

// File: tb/tb_tmr16_top.sv
module tb_tmr16_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int failures = 0;

    localparam logic [7:0] CTRL = 8'h00, CMD = 8'h04, IEN = 8'h0C, FLG = 8'h10,
                           FSET = 8'h14, FCLR = 8'h18, RELD = 8'h1C, CNT = 8'h24;

    tmr16_top dut (.*);

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1 bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        rd(CTRL, v); chk("R1 ctrl", v, 0);
        rd(RELD, v); chk("R1 reload", v, 32'hFFFF);
        rd(CNT, v);  chk("R1 count", v, 0);
        rd(FLG, v);  chk("R1 flags", v, 0);
        chk("R1 irq", irq, 0);
        repeat (3) @(negedge clk);
        rd(CNT, v);  chk("R1 stopped", v, 0);
        rd(CMD, v);  chk("R2 cmd reads 0", v, 0);
    endtask

    task automatic t_down_periodic();
        logic [31:0] v, held;
        wr(RELD, 5); wr(CNT, 3); wr(CTRL, 1); wr(IEN, 2); wr(CMD, 1);
        @(negedge clk); rd(CNT, v); chk("R8 preload", v, 3);
        @(negedge clk); rd(CNT, v); chk("R4 step", v, 2);
        repeat (3) @(negedge clk);
        rd(CNT, v); chk("R4 reload", v, 5);
        rd(FLG, v); chk("R4 unf flag", v, 2);
        chk("R9 irq", irq, 1);
        @(negedge clk); rd(CNT, v); chk("R4 periodic", v, 4);
        wr(CMD, 2);
        @(negedge clk); rd(CNT, held);
        repeat (5) @(negedge clk);
        rd(CNT, v); chk("R7 hold", v, held);
        wr(FCLR, 3);
        @(negedge clk); rd(FLG, v); chk("R9 clear", v, 0);
        chk("R9 irq low", irq, 0);
    endtask

    task automatic t_up_single();
        logic [31:0] v;
        wr(CNT, 0); wr(RELD, 2); wr(IEN, 0);
        wr(CTRL, (32'd2 << 24) | 32'h10); wr(CMD, 1);
        repeat (4) @(negedge clk); rd(CNT, v); chk("R3 before tick", v, 0);
        @(negedge clk);            rd(CNT, v); chk("R3 first tick", v, 1);
        repeat (4) @(negedge clk); rd(CNT, v); chk("R5 up", v, 2);
        repeat (4) @(negedge clk); rd(CNT, v); chk("R5 wrap", v, 0);
        rd(FLG, v); chk("R5 ovf flag", v, 1);
        chk("R9 masked", irq, 0);
        repeat (10) @(negedge clk); rd(CNT, v); chk("R6 stopped", v, 0);
        wr(CMD, 1);
        repeat (4) @(negedge clk); rd(CNT, v); chk("R3 restart", v, 0);
        @(negedge clk);            rd(CNT, v); chk("R3 restart tick", v, 1);
        wr(CMD, 2); wr(FCLR, 3);
    endtask

    task automatic t_stop_wins();
        logic [31:0] v;
        wr(CTRL, 1); wr(CNT, 7); wr(CMD, 3);
        repeat (6) @(negedge clk);
        rd(CNT, v); chk("R7 stop wins", v, 7);
    endtask

    task automatic t_flag_alias();
        logic [31:0] v;
        wr(FSET, 1);
        @(negedge clk); rd(FLG, v); chk("R9 set", v, 1);
        chk("R9 irq masked", irq, 0);
        wr(IEN, 1);
        @(negedge clk); chk("R9 irq enabled", irq, 1);
        rd(FSET, v); chk("R2 set alias reads 0", v, 0);
        wr(FCLR, 1);
        @(negedge clk); rd(FLG, v); chk("R9 cleared", v, 0);
        chk("R9 irq off", irq, 0);
    endtask

    task automatic t_priority();
        logic [31:0] v;
        wr(CTRL, 1); wr(RELD, 9); wr(CNT, 2); wr(CMD, 1);
        repeat (2) @(posedge clk);
        wr(FCLR, 2);
        @(negedge clk); rd(FLG, v); chk("R10 hw beats clear", v, 2);
        rd(CNT, v); chk("R4 reload 9", v, 9);
        wr(CMD, 2); wr(FCLR, 3);
    endtask

    task automatic t_div1024();
        logic [31:0] v;
        wr(CTRL, (32'd10 << 24) | 32'd1); wr(CNT, 5); wr(CMD, 1);
        repeat (1024) @(negedge clk); rd(CNT, v); chk("R3 div1024 early", v, 5);
        @(negedge clk);               rd(CNT, v); chk("R3 div1024 step", v, 4);
        rd(CTRL, v); chk("R2 ctrl fields", v, 32'h0A00_0001);
        wr(CMD, 2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_down_periodic();
        t_up_single();
        t_stop_wins();
        t_flag_alias();
        t_priority();
        t_div1024();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule